// File: doc/BRIEF.md
# Outstanding Transaction Tracker

This block is a passive observer attached to the five channels of a burst-based memory-mapped interface. It samples only the valid/ready pairs and the end-of-burst markers, and keeps two live counts: how many reads and how many writes are currently in flight. It never drives anything back onto the interface.

A read is counted from its address handshake until the data handshake that carries the end-of-burst marker. A write is counted from whichever arrives first, its address or the first beat of its data, until its response handshake. Writes whose data leads the address are paired with later addresses, and addresses waiting for data are paired with later first data beats. This pairing keeps a single write from being counted twice. Each count has a flag that shows when it has reached a configured maximum. A sticky error flag records a completion that had nothing to complete.

Top module: `txn_tracker`

## Requirements
- R1: A handshake on the read-address channel raises `rd_active` by one, visible in the cycle after the clock edge.
- R2: A read-data handshake with `r_last` high lowers `rd_active` by one. A read-data handshake with `r_last` low leaves the count unchanged.
- R3: When a read-address handshake and a final read-data handshake share an edge, `rd_active` is unchanged.
- R4: A channel event is taken only at an edge where both its valid and its ready are high. Valid alone or ready alone changes no output.
- R5: A write-address handshake with no unmatched leading data burst raises `wr_active` by one. The first data beat that later joins that address does not raise it again.
- R6: The first data beat of a burst, meaning the first write-data handshake after reset or after a beat with `w_last` high, raises `wr_active` by one when no address is waiting for data. A later address that joins that burst does not raise it again. Later beats of the same burst never change the count.
- R7: A write-address handshake and a first data beat on the same edge together add exactly one write.
- R8: A write-response handshake lowers `wr_active` by one.
- R9: A final read-data handshake while `rd_active` is zero, or a response handshake while `wr_active` is zero, sets `underflow_err` from the next cycle on and leaves that count at zero. The flag stays high until reset.
- R10: `rd_at_limit` is high exactly when `rd_active` is at least `MAX_RD`, and `wr_at_limit` is high exactly when `wr_active` is at least `MAX_WR`.
- R11: After reset both counts are zero and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ar_valid | input | 1 | Read-address valid |
| ar_ready | input | 1 | Read-address ready |
| r_valid | input | 1 | Read-data valid |
| r_ready | input | 1 | Read-data ready |
| r_last | input | 1 | Final beat of a read burst |
| aw_valid | input | 1 | Write-address valid |
| aw_ready | input | 1 | Write-address ready |
| w_valid | input | 1 | Write-data valid |
| w_ready | input | 1 | Write-data ready |
| w_last | input | 1 | Final beat of a write burst |
| b_valid | input | 1 | Write-response valid |
| b_ready | input | 1 | Write-response ready |
| rd_active | output | CNT_W | Reads in flight |
| wr_active | output | CNT_W | Writes in flight |
| rd_at_limit | output | 1 | Read count at or above MAX_RD |
| wr_at_limit | output | 1 | Write count at or above MAX_WR |
| underflow_err | output | 1 | Sticky: a completion arrived with its count at zero |

## Verification
The assertions assume that the observed traffic pairs each write address with exactly one data burst. They also assume that neither count nor either pending-pairing tally wraps its counter width. Under these assumptions the step rules for each count follow from the handshakes alone. The directed stimulus keeps every in-flight total well below the counter range. It produces each completion without a matching start only once, in the final underflow scenario, so that the error flag is set at a known point.

// File: rtl/txn_pkg.sv
package txn_pkg;
  // One counting step: an increment request and a decrement request.
  typedef struct packed {
    logic up;
    logic down;
  } step_t;
endpackage

// File: rtl/txn_counter.sv
module txn_counter
  import txn_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_t            step,
  output logic [CNT_W-1:0] cnt,
  output logic             at_limit,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dec, cnt_en;

  always_comb begin
    underflow = step.down && (cnt_q == '0);
    dec       = step.down && !underflow;
    cnt_en    = step.up ^ dec;
    cnt_d     = cnt_q;
    if (step.up && !dec)      cnt_d = cnt_q + 1'b1;
    else if (dec && !step.up) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt      = cnt_q;
  assign at_limit = (cnt_q >= LIM_C);
endmodule

// File: rtl/wr_start_matcher.sv
module wr_start_matcher #(
  parameter int PEND_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic aw_hs,
  input  logic w_hs,
  input  logic w_last,
  output logic start_wr
);
  logic [PEND_W-1:0] lead_q, lead_d;   // data bursts still waiting for an address
  logic [PEND_W-1:0] await_q, await_d; // addresses still waiting for data
  logic              mid_q, mid_d;     // inside a data burst
  logic              first_w, pend_en, mid_en;

  always_comb begin
    first_w  = w_hs && !mid_q;
    lead_d   = lead_q;
    await_d  = await_q;
    start_wr = 1'b0;
    if (aw_hs && first_w) begin
      start_wr = 1'b1;                 // one new write; pending tallies shift by zero
    end else if (aw_hs) begin
      if (lead_q != '0) lead_d = lead_q - 1'b1;
      else begin
        await_d  = await_q + 1'b1;
        start_wr = 1'b1;
      end
    end else if (first_w) begin
      if (await_q != '0) await_d = await_q - 1'b1;
      else begin
        lead_d   = lead_q + 1'b1;
        start_wr = 1'b1;
      end
    end
    pend_en = aw_hs ^ first_w;
    mid_en  = w_hs;
    mid_d   = !w_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_q  <= '0;
      await_q <= '0;
    end else if (pend_en) begin
      lead_q  <= lead_d;
      await_q <= await_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mid_q <= 1'b0;
    else if (mid_en) mid_q <= mid_d;
  end
endmodule

// File: rtl/txn_tracker.sv
module txn_tracker
  import txn_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int PEND_W = 4,
  parameter int MAX_RD = 8,
  parameter int MAX_WR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ar_valid,
  input  logic             ar_ready,
  input  logic             r_valid,
  input  logic             r_ready,
  input  logic             r_last,
  input  logic             aw_valid,
  input  logic             aw_ready,
  input  logic             w_valid,
  input  logic             w_ready,
  input  logic             w_last,
  input  logic             b_valid,
  input  logic             b_ready,
  output logic [CNT_W-1:0] rd_active,
  output logic [CNT_W-1:0] wr_active,
  output logic             rd_at_limit,
  output logic             wr_at_limit,
  output logic             underflow_err
);
  logic  ar_hs, rl_hs, aw_hs, w_hs, b_hs, start_wr;
  logic  rd_uf, wr_uf, err_q, err_en;
  step_t rd_step, wr_step;

  always_comb begin
    ar_hs        = ar_valid && ar_ready;
    rl_hs        = r_valid && r_ready && r_last;
    aw_hs        = aw_valid && aw_ready;
    w_hs         = w_valid && w_ready;
    b_hs         = b_valid && b_ready;
    rd_step.up   = ar_hs;
    rd_step.down = rl_hs;
    wr_step.up   = start_wr;
    wr_step.down = b_hs;
    err_en       = (rd_uf || wr_uf) && !err_q;
  end

  wr_start_matcher #(.PEND_W(PEND_W)) u_match (
    .clk(clk), .rst_n(rst_n), .aw_hs(aw_hs), .w_hs(w_hs),
    .w_last(w_last), .start_wr(start_wr)
  );

  txn_counter #(.CNT_W(CNT_W), .LIMIT(MAX_RD)) u_rd_cnt (
    .clk(clk), .rst_n(rst_n), .step(rd_step), .cnt(rd_active),
    .at_limit(rd_at_limit), .underflow(rd_uf)
  );

  txn_counter #(.CNT_W(CNT_W), .LIMIT(MAX_WR)) u_wr_cnt (
    .clk(clk), .rst_n(rst_n), .step(wr_step), .cnt(wr_active),
    .at_limit(wr_at_limit), .underflow(wr_uf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= 1'b1;
  end

  assign underflow_err = err_q;
endmodule

// File: rtl/txn_tracker_chk.sv
module txn_tracker_chk #(
  parameter int CNT_W  = 4,
  parameter int MAX_RD = 8,
  parameter int MAX_WR = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ar_valid,
  input logic             ar_ready,
  input logic             r_valid,
  input logic             r_ready,
  input logic             r_last,
  input logic             aw_valid,
  input logic             aw_ready,
  input logic             w_valid,
  input logic             w_ready,
  input logic             b_valid,
  input logic             b_ready,
  input logic [CNT_W-1:0] rd_active,
  input logic [CNT_W-1:0] wr_active,
  input logic             rd_at_limit,
  input logic             wr_at_limit,
  input logic             underflow_err
);
  logic ar_e, rl_e, aw_e, w_e, b_e;
  assign ar_e = ar_valid && ar_ready;
  assign rl_e = r_valid && r_ready && r_last;
  assign aw_e = aw_valid && aw_ready;
  assign w_e  = w_valid && w_ready;
  assign b_e  = b_valid && b_ready;

  a_r1_read_start: assert property (@(posedge clk) disable iff (!rst_n)
    ar_e && !rl_e |=> rd_active == $past(rd_active) + 1'b1);

  a_r2_read_end: assert property (@(posedge clk) disable iff (!rst_n)
    rl_e && !ar_e && rd_active != '0 |=> rd_active == $past(rd_active) - 1'b1);

  a_r3_read_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ar_e && rl_e && rd_active != '0 |=> $stable(rd_active));

  a_r4_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ar_e && !rl_e |=> $stable(rd_active));

  a_r4_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !aw_e && !w_e && !b_e |=> $stable(wr_active));

  a_r8_write_end: assert property (@(posedge clk) disable iff (!rst_n)
    b_e && !aw_e && !w_e && wr_active != '0 |=> wr_active == $past(wr_active) - 1'b1);

  a_r9_underflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rl_e && rd_active == '0) || (b_e && wr_active == '0) |=> underflow_err);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);

  a_r10_limits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_at_limit == (rd_active >= CNT_W'(MAX_RD))) &&
    (wr_at_limit == (wr_active >= CNT_W'(MAX_WR))));
endmodule

bind txn_tracker txn_tracker_chk #(.CNT_W(CNT_W), .MAX_RD(MAX_RD), .MAX_WR(MAX_WR)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ar_valid(ar_valid), .ar_ready(ar_ready),
  .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last),
  .aw_valid(aw_valid), .aw_ready(aw_ready),
  .w_valid(w_valid), .w_ready(w_ready),
  .b_valid(b_valid), .b_ready(b_ready),
  .rd_active(rd_active), .wr_active(wr_active),
  .rd_at_limit(rd_at_limit), .wr_at_limit(wr_at_limit),
  .underflow_err(underflow_err)
);

// File: tb/txn_tracker_test.sv
module txn_tracker_test;
  localparam int CNT_W = 4;
  localparam int MAXR  = 4;
  localparam int MAXW  = 4;
  // Channel bit order in drive vectors: 0 AR, 1 R, 2 AW, 3 W, 4 B
  localparam logic [4:0] AR = 5'b00001, RD = 5'b00010, AW = 5'b00100,
                         WD = 5'b01000, BR = 5'b10000;

  logic clk, rst_n;
  logic ar_valid, ar_ready, r_valid, r_ready, r_last;
  logic aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready;
  logic [CNT_W-1:0] rd_active, wr_active;
  logic rd_at_limit, wr_at_limit, underflow_err;
  int total, bad;
  bit done;

  txn_tracker #(.CNT_W(CNT_W), .PEND_W(4), .MAX_RD(MAXR), .MAX_WR(MAXW)) uut (
    .clk(clk), .rst_n(rst_n),
    .ar_valid(ar_valid), .ar_ready(ar_ready),
    .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last),
    .aw_valid(aw_valid), .aw_ready(aw_ready),
    .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready),
    .rd_active(rd_active), .wr_active(wr_active),
    .rd_at_limit(rd_at_limit), .wr_at_limit(wr_at_limit),
    .underflow_err(underflow_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive valids and readies for one edge, then return to idle at the next falling edge.
  task automatic cyc(input logic [4:0] v, input logic [4:0] rdy,
                     input logic rl, input logic wl);
    {b_valid, w_valid, aw_valid, r_valid, ar_valid} = v;
    {b_ready, w_ready, aw_ready, r_ready, ar_ready} = rdy;
    r_last = rl;
    w_last = wl;
    @(posedge clk);
    @(negedge clk);
    {b_valid, w_valid, aw_valid, r_valid, ar_valid} = '0;
    {b_ready, w_ready, aw_ready, r_ready, ar_ready} = '0;
    r_last = 1'b0;
    w_last = 1'b0;
  endtask

  task automatic hs(input logic [4:0] ch, input logic rl, input logic wl);
    cyc(ch, ch, rl, wl);
  endtask

  task automatic t_reset;
    chk("R11 rd_active", rd_active, 0);
    chk("R11 wr_active", wr_active, 0);
    chk("R11 flags", {rd_at_limit, wr_at_limit, underflow_err}, 0);
  endtask

  task automatic t_read;
    hs(AR, 0, 0);            chk("R1 ar start", rd_active, 1);
    hs(RD, 0, 0);            chk("R2 non-last beat", rd_active, 1);
    hs(RD, 1, 0);            chk("R2 last beat", rd_active, 0);
  endtask

  task automatic t_half;
    cyc(AR | RD, 5'b0, 1, 0); chk("R4 valid only", rd_active, 0);
    cyc(5'b0, AR | AW, 0, 0); chk("R4 ready only", rd_active, 0);
    cyc(AW | WD | BR, 5'b0, 0, 1); chk("R4 write valid only", wr_active, 0);
  endtask

  task automatic t_same;
    hs(AR, 0, 0);
    hs(AR | RD, 1, 0);       chk("R3 same edge", rd_active, 1);
    hs(RD, 1, 0);            chk("R3 drain", rd_active, 0);
  endtask

  task automatic t_aw_first;
    hs(AW, 0, 0);            chk("R5 aw start", wr_active, 1);
    hs(WD, 0, 0);            chk("R5 joined data", wr_active, 1);
    hs(WD, 0, 1);            chk("R6 later beat", wr_active, 1);
    hs(BR, 0, 0);            chk("R8 response", wr_active, 0);
  endtask

  task automatic t_w_first;
    hs(WD, 0, 0);            chk("R6 lead start", wr_active, 1);
    hs(WD, 0, 1);            chk("R6 second beat", wr_active, 1);
    hs(AW, 0, 0);            chk("R6 joined addr", wr_active, 1);
    hs(BR, 0, 0);            chk("R8 response", wr_active, 0);
    hs(WD, 0, 1);
    hs(WD, 0, 1);            chk("R6 two lead bursts", wr_active, 2);
    hs(AW, 0, 0);
    hs(AW, 0, 0);            chk("R6 two joined addrs", wr_active, 2);
    hs(BR, 0, 0);
    hs(BR, 0, 0);            chk("R8 drain", wr_active, 0);
  endtask

  task automatic t_both;
    hs(AW | WD, 0, 1);       chk("R7 same edge", wr_active, 1);
    hs(AW, 0, 0);            chk("R7 next addr", wr_active, 2);
    hs(AW | WD, 0, 1);       chk("R7 pair with waiting addr", wr_active, 3);
    hs(WD, 0, 1);            chk("R7 data joins", wr_active, 3);
    hs(BR, 0, 0); hs(BR, 0, 0); hs(BR, 0, 0);
    chk("R8 drain", wr_active, 0);
  endtask

  task automatic t_limit;
    for (int i = 0; i < MAXR - 1; i++) hs(AR, 0, 0);
    chk("R10 below read limit", rd_at_limit, 0);
    hs(AR, 0, 0);            chk("R10 at read limit", rd_at_limit, 1);
    hs(AR, 0, 0);            chk("R10 above read limit", rd_at_limit, 1);
    for (int i = 0; i < MAXR + 1; i++) hs(RD, 1, 0);
    chk("R10 read drained", {rd_at_limit, rd_active}, 0);
    for (int i = 0; i < MAXW; i++) hs(WD, 0, 1);
    chk("R10 at write limit", wr_at_limit, 1);
    for (int i = 0; i < MAXW; i++) hs(AW, 0, 0);
    hs(BR, 0, 0);            chk("R10 below write limit", wr_at_limit, 0);
    for (int i = 0; i < MAXW - 1; i++) hs(BR, 0, 0);
    chk("R8 write drained", wr_active, 0);
    chk("R9 no error yet", underflow_err, 0);
  endtask

  task automatic t_underflow;
    hs(BR, 0, 0);            chk("R9 write underflow flag", underflow_err, 1);
    chk("R9 write count held", wr_active, 0);
    hs(RD, 1, 0);            chk("R9 read count held", rd_active, 0);
    repeat (3) @(negedge clk);
    chk("R9 sticky", underflow_err, 1);
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    rst_n = 1'b0;
    {b_valid, w_valid, aw_valid, r_valid, ar_valid} = '0;
    {b_ready, w_ready, aw_ready, r_ready, ar_ready} = '0;
    r_last = 1'b0; w_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_half();
    t_same();
    t_aw_first();
    t_w_first();
    t_both();
    t_limit();
    t_underflow();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule